// File: doc/BRIEF.md
# Commit-Ordered Store Buffer

This block sits between the execute stage of a pipeline and the data memory write port. A store that executes does not write memory. Its word address, data, byte-enable mask and program-order tag are placed in a small circular queue. Memory is written from that queue only after the pipeline's commit logic confirms the store, and the queue hands stores to memory in the order they were accepted.

When an older instruction raises an exception, or the pipeline flushes for any other reason, the queue drops every store that has not yet been confirmed. Confirmed stores stay and still reach memory. A younger store therefore cannot change memory ahead of an older instruction that faulted.

Loads issued behind the buffered stores look up the queue. When a buffered store supplies every byte the load asks for, its data is forwarded to the load. When a store supplies only some of those bytes, the load is told to stall until that store has left the queue.

Top module: `stqb_commit_buf`

## Requirements
- R1: A store is never presented on the memory port before its commit is accepted. While no committed entry is held, `mem_wr_valid` stays low.
- R2: A commit is accepted only when `cmt_tag` equals the tag of the oldest uncommitted entry. Any other commit request is ignored and has no effect.
- R3: Committed stores are written to memory in the order they were accepted. One store leaves per cycle in which `mem_wr_valid` and `mem_ready` are both high. While `mem_ready` is low, the memory outputs hold their values.
- R4: `flush` removes every uncommitted entry, and the committed entries still drain. A store offered in the same cycle as `flush` is dropped. A commit accepted in the same cycle as `flush` makes that entry survive the flush.
- R5: `st_full` is high exactly when DEPTH entries are held. A store offered while `st_full` is high is ignored.
- R6: A load is forwarded only if a buffered entry has the same word address and a mask that overlaps `ld_mask`. Among such entries, the most recently accepted one decides the result. If its mask contains every bit of `ld_mask`, `ld_hit` is high and `ld_data` equals that entry's data.
- R7: If that deciding entry covers only part of `ld_mask`, `ld_stall` is high and `ld_hit` is low.
- R8: If no buffered entry matches the address with an overlapping mask, or `ld_valid` is low, both `ld_hit` and `ld_stall` are low.
- R9: After reset the buffer is empty: `st_full`, `mem_wr_valid`, `ld_hit` and `ld_stall` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered from execute |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_mask | input | DW/8 | Store byte enables (bit i = byte i) |
| st_tag | input | TW | Program-order tag of the store |
| st_full | output | 1 | Queue holds DEPTH entries; new stores are refused |
| cmt_valid | input | 1 | Commit request |
| cmt_tag | input | TW | Tag being committed |
| flush | input | 1 | Discard all uncommitted entries |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load word address |
| ld_mask | input | DW/8 | Bytes the load needs |
| ld_hit | output | 1 | Forwarded data is valid |
| ld_stall | output | 1 | Partial overlap; the load must wait |
| ld_data | output | DW | Forwarded data |
| mem_wr_valid | output | 1 | Oldest committed store presented to memory |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| mem_addr | output | AW | Write word address |
| mem_data | output | DW | Write data |
| mem_mask | output | DW/8 | Write byte enables |

## Verification
The assertions assume that `mem_ready` reflects only the memory side and that a load lookup is younger than every buffered store. Under these assumptions, "most recent matching entry" is the correct forwarding source. Commit tags are not trusted: a wrong tag must be ignored, so the checks do not depend on the commit side behaving well. The stimulus offers loads only while the stores it is probing are buffered. It changes `mem_ready` independently of the queue state, and it deliberately sends commits with wrong tags and stores while the queue is full.

// File: rtl/stqb_pkg.sv
package stqb_pkg;
    typedef enum logic [1:0] {
        FWD_MISS  = 2'd0,
        FWD_HIT   = 2'd1,
        FWD_STALL = 2'd2
    } fwd_res_e;
endpackage

// File: rtl/stqb_fwd.sv
module stqb_fwd
    import stqb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int MW   = DW / 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [DEPTH-1:0][DW-1:0] ent_data,
    input  logic [DEPTH-1:0][MW-1:0] ent_mask,
    input  logic [PW-1:0]            head,
    input  logic [CW-1:0]            occ,
    input  logic                     ld_valid,
    input  logic [AW-1:0]            ld_addr,
    input  logic [MW-1:0]            ld_mask,
    output fwd_res_e                 res,
    output logic [DW-1:0]            data
);
    logic [PW-1:0] idx;
    logic [MW-1:0] ovl;

    // Walk oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        res  = FWD_MISS;
        data = '0;
        idx  = head;
        ovl  = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PW'(k);
            ovl = ent_mask[idx] & ld_mask;
            if (ld_valid && (k < int'(occ)) && (ent_addr[idx] == ld_addr) && (|ovl)) begin
                if (ovl == ld_mask) begin
                    res  = FWD_HIT;
                    data = ent_data[idx];
                end else begin
                    res  = FWD_STALL;
                    data = '0;
                end
            end
        end
    end
endmodule

// File: rtl/stqb_port.sv
module stqb_port #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int MW   = DW / 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [DEPTH-1:0][DW-1:0] ent_data,
    input  logic [DEPTH-1:0][MW-1:0] ent_mask,
    input  logic [PW-1:0]            head,
    input  logic [CW-1:0]            ncmt,
    output logic                     wr_valid,
    output logic [AW-1:0]            wr_addr,
    output logic [DW-1:0]            wr_data,
    output logic [MW-1:0]            wr_mask
);
    always_comb begin
        wr_valid = (ncmt != '0);
        wr_addr  = ent_addr[head];
        wr_data  = ent_data[head];
        wr_mask  = wr_valid ? ent_mask[head] : '0;
    end
endmodule

// File: rtl/stqb_commit_buf.sv
module stqb_commit_buf
    import stqb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int TW    = 6,
    localparam int MW   = DW / 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [MW-1:0] st_mask,
    input  logic [TW-1:0] st_tag,
    output logic          st_full,
    input  logic          cmt_valid,
    input  logic [TW-1:0] cmt_tag,
    input  logic          flush,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [MW-1:0] ld_mask,
    output logic          ld_hit,
    output logic          ld_stall,
    output logic [DW-1:0] ld_data,
    output logic          mem_wr_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    output logic [MW-1:0] mem_mask
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [MW-1:0] mask;
        logic [TW-1:0] tag;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [PW-1:0]    head;
        logic [PW-1:0]    tail;
        logic [CW-1:0]    occ;
        logic [CW-1:0]    ncmt;
    } state_t;

    state_t s_d, s_q;

    logic [CW-1:0] occ;
    logic [CW-1:0] ncmt;
    logic [DEPTH-1:0][AW-1:0] e_addr;
    logic [DEPTH-1:0][DW-1:0] e_data;
    logic [DEPTH-1:0][MW-1:0] e_mask;

    logic          push, drain, cmt_ok;
    logic [PW-1:0] cmt_idx;
    fwd_res_e      fwd_res;

    assign occ     = s_q.occ;
    assign ncmt    = s_q.ncmt;
    assign st_full = (s_q.occ == CW'(DEPTH));

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign e_addr[g] = s_q.ent[g].addr;
        assign e_data[g] = s_q.ent[g].data;
        assign e_mask[g] = s_q.ent[g].mask;
    end

    stqb_port #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_port (
        .ent_addr (e_addr),
        .ent_data (e_data),
        .ent_mask (e_mask),
        .head     (s_q.head),
        .ncmt     (s_q.ncmt),
        .wr_valid (mem_wr_valid),
        .wr_addr  (mem_addr),
        .wr_data  (mem_data),
        .wr_mask  (mem_mask)
    );

    stqb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
        .ent_addr (e_addr),
        .ent_data (e_data),
        .ent_mask (e_mask),
        .head     (s_q.head),
        .occ      (s_q.occ),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .ld_mask  (ld_mask),
        .res      (fwd_res),
        .data     (ld_data)
    );

    assign ld_hit   = (fwd_res == FWD_HIT);
    assign ld_stall = (fwd_res == FWD_STALL);

    always_comb begin
        s_d     = s_q;
        drain   = mem_wr_valid && mem_ready;
        push    = st_valid && !st_full && !flush;
        cmt_idx = s_q.head + PW'(s_q.ncmt);
        cmt_ok  = cmt_valid && (s_q.ncmt < s_q.occ) && (s_q.ent[cmt_idx].tag == cmt_tag);

        if (push) begin
            s_d.ent[s_q.tail] = '{addr: st_addr, data: st_data, mask: st_mask, tag: st_tag};
            s_d.tail          = s_q.tail + PW'(1);
        end

        s_d.head = s_q.head + PW'(drain);
        s_d.occ  = s_q.occ + CW'(push) - CW'(drain);
        s_d.ncmt = s_q.ncmt + CW'(cmt_ok) - CW'(drain);

        // Flush keeps only the committed run that starts at the head.
        if (flush) begin
            s_d.occ  = s_d.ncmt;
            s_d.tail = s_d.head + PW'(s_d.ncmt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/stqb_chk.sv
module stqb_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int MW    = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          st_full,
    input logic          ld_hit,
    input logic          ld_stall,
    input logic          mem_wr_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data,
    input logic [MW-1:0] mem_mask,
    input logic [CW-1:0] occ,
    input logic [CW-1:0] ncmt
);
    // R1: committed count never exceeds occupancy
    a_r1_cmt_within: assert property (@(posedge clk) disable iff (!rst_n) ncmt <= occ);

    // R1: nothing held means nothing written
    a_r1_empty_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !mem_wr_valid);

    // R3: a stalled write holds its values
    a_r3_hold_on_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_ready) |=>
            (mem_wr_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_mask)));

    // R4: after a flush only committed entries remain
    a_r4_flush_leaves_committed: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == ncmt));

    // R5: a full queue cannot shrink without a drain or a flush
    a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_full && !(mem_wr_valid && mem_ready) && !flush) |=> st_full);

    // R5: occupancy bounded by depth
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    // R7: stall and hit never together
    a_r7_hit_stall_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hit && ld_stall));
endmodule

bind stqb_commit_buf stqb_chk #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .DW    (DW),
    .MW    (MW),
    .CW    (CW)
) u_chk (.*);

// File: tb/test_stqb_commit_buf.sv
module test_stqb_commit_buf;
    localparam int DEPTH = 4;
    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam int TW    = 4;
    localparam int MW    = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [MW-1:0] st_mask = '0;
    logic [TW-1:0] st_tag = '0;
    logic          st_full;
    logic          cmt_valid = 1'b0;
    logic [TW-1:0] cmt_tag = '0;
    logic          flush = 1'b0;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [MW-1:0] ld_mask = '0;
    logic          ld_hit, ld_stall;
    logic [DW-1:0] ld_data;
    logic          mem_wr_valid;
    logic          mem_ready = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic [MW-1:0] mem_mask;

    int checks = 0;
    int failures = 0;
    int wlog = 0;
    logic [AW-1:0] log_addr [0:15];
    logic [DW-1:0] log_data [0:15];

    always #5 clk = ~clk;

    stqb_commit_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) i_stqb_commit_buf (.*);

    // Record each write that will be taken at the coming edge.
    always @(negedge clk) begin
        if (rst_n && mem_wr_valid && mem_ready) begin
            if (wlog < 16) begin
                log_addr[wlog] = mem_addr;
                log_data[wlog] = mem_data;
            end
            wlog++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [MW-1:0] m, input logic [TW-1:0] t);
        st_valid = 1'b1; st_addr = a; st_data = d; st_mask = m; st_tag = t;
        step();
        st_valid = 1'b0;
    endtask

    task automatic commit(input logic [TW-1:0] t);
        cmt_valid = 1'b1; cmt_tag = t;
        step();
        cmt_valid = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        step();
        flush = 1'b0;
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [MW-1:0] m);
        ld_valid = 1'b1; ld_addr = a; ld_mask = m;
        #1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R9 reset state
        check(!st_full && !mem_wr_valid, "R9 reset empty", {st_full, mem_wr_valid}, 0);
        load(8'h10, 4'hF);
        check(!ld_hit && !ld_stall, "R9 reset no forward", {ld_hit, ld_stall}, 0);
        ld_valid = 1'b0;

        push(8'h10, 32'h1111_1111, 4'hF, 4'd1);
        push(8'h20, 32'h2222_2222, 4'hF, 4'd2);
        push(8'h10, 32'h3333_3333, 4'h3, 4'd3);
        check(!st_full, "R5 not full at three", st_full, 0);
        push(8'h30, 32'h4444_4444, 4'hF, 4'd4);
        check(st_full, "R5 full at depth", st_full, 1);
        push(8'h40, 32'h5555_5555, 4'hF, 4'd5);
        check(st_full, "R5 still full", st_full, 1);

        step(); step();
        check(wlog == 0 && !mem_wr_valid, "R1 no write before commit", wlog, 0);

        // R6 / R7 / R8 forwarding
        load(8'h20, 4'hF);
        check(ld_hit && ld_data == 32'h2222_2222, "R6 full hit", ld_data, 32'h2222_2222);
        load(8'h10, 4'hF);
        check(ld_stall && !ld_hit, "R7 youngest partial stalls", {ld_hit, ld_stall}, 1);
        load(8'h10, 4'h3);
        check(ld_hit && ld_data == 32'h3333_3333, "R6 youngest wins", ld_data, 32'h3333_3333);
        load(8'h10, 4'hC);
        check(ld_hit && ld_data == 32'h1111_1111, "R6 older covers when younger disjoint", ld_data, 32'h1111_1111);
        load(8'h40, 4'hF);
        check(!ld_hit && !ld_stall, "R5 store offered while full absent", {ld_hit, ld_stall}, 0);
        load(8'h50, 4'hF);
        check(!ld_hit && !ld_stall, "R8 no address match", {ld_hit, ld_stall}, 0);
        ld_valid = 1'b0; #1;
        load(8'h20, 4'hF); ld_valid = 1'b0; #1;
        check(!ld_hit && !ld_stall, "R8 ld_valid low", {ld_hit, ld_stall}, 0);

        // R2 wrong tag ignored
        commit(4'd3);
        step(); step();
        check(wlog == 0 && !mem_wr_valid, "R2 wrong tag ignored", wlog, 0);

        // R3 / R4 commit two, flush rest, backpressure
        mem_ready = 1'b0;
        commit(4'd1);
        commit(4'd2);
        do_flush();
        check(mem_wr_valid && mem_addr == 8'h10 && mem_data == 32'h1111_1111,
              "R3 head presented", mem_data, 32'h1111_1111);
        check(!st_full, "R4 flush freed space", st_full, 0);
        for (int i = 0; i < 3; i++) begin
            step();
            check(mem_wr_valid && mem_addr == 8'h10 && mem_mask == 4'hF, "R3 hold while not ready", mem_addr, 8'h10);
        end
        mem_ready = 1'b1;
        step(); step(); step(); step();
        check(wlog == 2, "R4 only committed drained", wlog, 2);
        check(log_addr[0] == 8'h10 && log_data[0] == 32'h1111_1111, "R3 first write", log_data[0], 32'h1111_1111);
        check(log_addr[1] == 8'h20 && log_data[1] == 32'h2222_2222, "R3 second write", log_data[1], 32'h2222_2222);
        check(!mem_wr_valid && !st_full, "R3 empty after drain", mem_wr_valid, 0);

        // R4 store offered with flush is dropped
        flush = 1'b1;
        push(8'h60, 32'h6666_6666, 4'hF, 4'd6);
        flush = 1'b0;
        load(8'h60, 4'hF);
        check(!ld_hit && !ld_stall, "R4 store in flush cycle dropped", {ld_hit, ld_stall}, 0);
        ld_valid = 1'b0;

        // R4 commit in flush cycle survives
        push(8'h61, 32'h6161_6161, 4'hF, 4'd7);
        push(8'h62, 32'h6262_6262, 4'hF, 4'd8);
        cmt_valid = 1'b1; cmt_tag = 4'd7; flush = 1'b1;
        step();
        cmt_valid = 1'b0; flush = 1'b0;
        step(); step(); step();
        check(wlog == 3 && log_addr[2] == 8'h61, "R4 commit with flush survives", log_addr[2], 8'h61);
        load(8'h62, 4'hF);
        check(!ld_hit && !ld_stall, "R4 uncommitted flushed", {ld_hit, ld_stall}, 0);
        ld_valid = 1'b0;

        // R6 / R7 / R8 mask sweep with one buffered store
        for (int s = 1; s < 16; s++) begin
            push(8'h70, 32'hA000_0000 | s, MW'(s), 4'd9);
            for (int l = 0; l < 16; l++) begin
                logic [3:0] ov;
                logic e_hit, e_stall;
                ov      = 4'(s & l);
                e_hit   = (ov != 0) && (ov == 4'(l));
                e_stall = (ov != 0) && !e_hit;
                load(8'h70, MW'(l));
                check(ld_hit == e_hit && ld_stall == e_stall, "R6 R7 R8 mask sweep",
                      {ld_hit, ld_stall}, {e_hit, e_stall});
                if (e_hit)
                    check(ld_data == (32'hA000_0000 | s), "R6 sweep data", ld_data, 32'hA000_0000 | s);
            end
            ld_valid = 1'b0;
            do_flush();
        end
        check(wlog == 3, "R1 sweep stores never written", wlog, 3);

        finish_run();
    end
endmodule